// File: doc/BRIEF.md
# Serial Byte Receiver with Burst FIFO

This block is the receive side of a synchronous serial slave port. A host drives three lines: a serial clock, a framing strobe and a data line. The block oversamples all three in the system clock domain and takes one data bit on every rising edge of the serial clock, most significant bit first. After eight bits it has a complete byte, which it writes into a 256-entry byte FIFO. A rising edge on the framing strobe drops any partial byte, so the next bit taken is a byte's MSB.

The FIFO is written so that its storage maps onto block RAM with a registered read port. On-chip logic takes bytes out through a valid/ready handshake. An active-low request output stays low while fewer than 64 bytes are stored. A host can therefore send a burst whenever the request is low, without polling a status word. A byte that completes while the FIFO is full is discarded, and a sticky overflow flag is raised.

Top module: `srx_serial_in`

## Requirements
- R1: A data bit is taken on each rising edge of the serial clock. The first bit of a byte becomes bit 7 of the byte and the eighth bit becomes bit 0.
- R2: A rising edge of the framing strobe, made while the serial clock is low, discards any partly received bits. The next bit taken is then bit 7 of a new byte.
- R3: Once eight bits have been taken, the following bit starts a new byte without another framing edge. After reset the first bit taken is bit 7 of a byte.
- R4: `fill_o` equals the number of bytes stored and not yet popped. It never exceeds 256 and changes by at most one per cycle.
- R5: `req_n_o` is low exactly when `fill_o` is below 64, and high when `fill_o` is 64 or more.
- R6: A byte that completes while `fill_o` is 256 is dropped, and the stored bytes are unchanged. `ovf_o` goes high and stays high until reset.
- R7: Bytes come out in arrival order. A byte is removed on a cycle where `pop_valid_o` and `pop_ready_i` are both high. `pop_valid_o` is high only while `fill_o` is nonzero. It rises within one cycle after `fill_o` becomes nonzero. `pop_data_o` holds steady while the byte waits for ready.
- R8: After reset `fill_o` is 0, `pop_valid_o` is 0, `req_n_o` is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock from the host, asynchronous |
| ser_sync_i | input | 1 | Framing strobe from the host; its rising edge realigns byte boundaries |
| ser_dat_i | input | 1 | Serial data from the host |
| req_n_o | output | 1 | Active-low request: low while fewer than 64 bytes are stored |
| ovf_o | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |
| fill_o | output | 9 | Number of bytes held in the FIFO |
| pop_valid_o | output | 1 | A byte is presented on pop_data_o |
| pop_data_o | output | 8 | Oldest stored byte |
| pop_ready_i | input | 1 | Consumer accepts the presented byte |

## Verification
The assertions assume that the serial clock holds each level for at least two system clock cycles, so that the synchronizer sees every edge. They also assume that data and the framing strobe change only while the serial clock is low, and that the strobe rises only then. Under these conditions the pop and occupancy properties depend only on the FIFO's own behaviour. The stimulus keeps each serial clock phase at four system clocks and changes data and the strobe only in the low phase. It leaves a gap after every byte, so each byte spans more than 64 system clocks. The pop-side ready is driven away from the clock edge in an uneven pattern, so that the properties on stalls and held data are exercised.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // Per-cycle events extracted from the oversampled serial lines.
  typedef struct packed {
    logic clk_rise;   // serial clock went low -> high
    logic sync_rise;  // framing strobe went low -> high
    logic dat;        // data line, aligned with clk_rise
  } srx_evt_t;
endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge
  import srx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ser_clk,
  input  logic     ser_sync,
  input  logic     ser_dat,
  output srx_evt_t evt
);
  // Bit 0: serial clock, bit 1: framing strobe, bit 2: data.
  logic [2:0] stg [STAGES];
  logic [2:0] prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= {ser_dat, ser_sync, ser_clk};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      evt  <= '0;
    end else begin
      prev          <= stg[STAGES-1];
      evt.clk_rise  <= stg[STAGES-1][0] & ~prev[0];
      evt.sync_rise <= stg[STAGES-1][1] & ~prev[1];
      evt.dat       <= stg[STAGES-1][2];
    end
  end
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  srx_evt_t      evt,
  output logic          byte_vld,
  output logic [DW-1:0] byte_dat
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] shifted;

  always_comb shifted = {shreg[DW-2:0], evt.dat};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (evt.sync_rise) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (evt.clk_rise) begin
        shreg <= shifted;
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          byte_dat <= shifted;
        end else begin
          bit_cnt <= bit_cnt + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH     = 256,
  parameter int DW        = 8,
  parameter int REQ_LEVEL = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_dat,
  input  logic          pop_ready,
  output logic          pop_valid,
  output logic [DW-1:0] pop_dat,
  output logic [CW-1:0] fill,
  output logic          req_n,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] REQ_CW = CW'(REQ_LEVEL);
  localparam logic [AW-1:0] PMAX   = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ, occ_nxt, ram_cnt;
  logic          out_vld, wr_en, ld, pop;
  logic [DW-1:0] out_q;

  always_comb begin
    pop     = out_vld & pop_ready;
    wr_en   = push & (occ != FULL);
    ram_cnt = occ - CW'(out_vld);
    ld      = (ram_cnt != '0) & (~out_vld | pop);
    occ_nxt = occ + CW'(wr_en) - CW'(pop);
  end

  // Storage and registered read port, no reset: block RAM friendly.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_dat;
  end

  always_ff @(posedge clk) begin
    if (ld) out_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      out_vld <= 1'b0;
      req_n   <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      occ   <= occ_nxt;
      req_n <= (occ_nxt >= REQ_CW);
      ovf   <= ovf | (push & ~wr_en);
      if (wr_en) wr_ptr <= (wr_ptr == PMAX) ? '0 : wr_ptr + AW'(1);
      if (ld) begin
        rd_ptr  <= (rd_ptr == PMAX) ? '0 : rd_ptr + AW'(1);
        out_vld <= 1'b1;
      end else if (pop) begin
        out_vld <= 1'b0;
      end
    end
  end

  assign pop_valid = out_vld;
  assign pop_dat   = out_q;
  assign fill      = occ;
endmodule

// File: rtl/srx_serial_in.sv
module srx_serial_in
  import srx_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int DW          = 8,
  parameter int REQ_LEVEL   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk_i,
  input  logic          ser_sync_i,
  input  logic          ser_dat_i,
  output logic          req_n_o,
  output logic          ovf_o,
  output logic [CW-1:0] fill_o,
  output logic          pop_valid_o,
  output logic [DW-1:0] pop_data_o,
  input  logic          pop_ready_i
);
  srx_evt_t      evt;
  logic          byte_vld;
  logic [DW-1:0] byte_dat;

  srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk_i),
    .ser_sync (ser_sync_i),
    .ser_dat  (ser_dat_i),
    .evt      (evt)
  );

  srx_deser #(.DW(DW)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat)
  );

  srx_fifo #(.DEPTH(DEPTH), .DW(DW), .REQ_LEVEL(REQ_LEVEL)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (byte_vld),
    .push_dat  (byte_dat),
    .pop_ready (pop_ready_i),
    .pop_valid (pop_valid_o),
    .pop_dat   (pop_data_o),
    .fill      (fill_o),
    .req_n     (req_n_o),
    .ovf       (ovf_o)
  );
endmodule

// File: rtl/srx_serial_in_chk.sv
module srx_serial_in_chk #(
  parameter int DEPTH     = 256,
  parameter int DW        = 8,
  parameter int REQ_LEVEL = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_n_o,
  input logic          ovf_o,
  input logic [CW-1:0] fill_o,
  input logic          pop_valid_o,
  input logic [DW-1:0] pop_data_o,
  input logic          pop_ready_i
);
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fill_o <= CW'(DEPTH));

  p_fill_step_r4: assert property (@(posedge clk) disable iff (rst)
    (fill_o == $past(fill_o)) || (fill_o == $past(fill_o) + CW'(1)) ||
    (fill_o + CW'(1) == $past(fill_o)));

  p_req_level_r5: assert property (@(posedge clk) disable iff (rst)
    req_n_o == (fill_o >= CW'(REQ_LEVEL)));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  p_full_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (fill_o == CW'(DEPTH)) && !pop_ready_i |=> fill_o == CW'(DEPTH));

  p_valid_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    pop_valid_o |-> fill_o != '0);

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_o != '0) && !pop_valid_o |=> pop_valid_o);

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (rst)
    pop_valid_o && !pop_ready_i |=> pop_valid_o && $stable(pop_data_o));
endmodule

bind srx_serial_in srx_serial_in_chk #(
  .DEPTH(DEPTH), .DW(DW), .REQ_LEVEL(REQ_LEVEL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_n_o     (req_n_o),
  .ovf_o       (ovf_o),
  .fill_o      (fill_o),
  .pop_valid_o (pop_valid_o),
  .pop_data_o  (pop_data_o),
  .pop_ready_i (pop_ready_i)
);

// File: tb/sim_srx_serial_in.sv
`timescale 1ns/1ps
module sim_srx_serial_in;
  localparam int DEPTH = 256;
  localparam int DW    = 8;
  localparam int REQ   = 64;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sclk = 1'b0, ssync = 1'b0, sdat = 1'b0;
  logic          req_n, ovf, pvalid, pready = 1'b0;
  logic [CW-1:0] fill;
  logic [DW-1:0] pdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] expq [$];

  always #2.5 clk = ~clk;

  srx_serial_in u0 (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_sync_i(ssync),
    .ser_dat_i(sdat), .req_n_o(req_n), .ovf_o(ovf), .fill_o(fill),
    .pop_valid_o(pvalid), .pop_data_o(pdata), .pop_ready_i(pready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle after a rising edge; never at an edge.
  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; sdat = b; step(4);
    sclk = 1'b1; step(4);
    sclk = 1'b0;
  endtask

  task automatic pulse_sync();
    sclk = 1'b0; ssync = 1'b1; step(4);
    ssync = 1'b0; step(4);
  endtask

  // R1: MSB first; the byte is expected only when the FIFO can keep it.
  task automatic send_byte(input logic [DW-1:0] b, input bit keep);
    for (int i = DW - 1; i >= 0; i--) send_bit(b[i]);
    if (keep) expq.push_back(b);
    step(12);
  endtask

  // Scoreboard monitor: compares every accepted byte with the queue head.
  always @(negedge clk) begin
    if (!rst && pvalid && pready) begin
      if (expq.size() == 0) begin
        chk("R7 unexpected pop", int'(pdata), -1);
      end else begin
        chk("R1/R7 popped byte", int'(pdata), int'(expq.pop_front()));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    settle();
    // R8: reset state
    chk("R8 fill", int'(fill), 0);
    chk("R8 valid", int'(pvalid), 0);
    chk("R8 req_n", int'(req_n), 0);
    chk("R8 ovf", int'(ovf), 0);
    step(1);
    rst = 1'b0;
    step(4);

    // R3: first byte after reset needs no framing edge; bytes chain.
    pready = 1'b1;
    send_byte(8'h96, 1'b1);
    send_byte(8'hA5, 1'b1);
    pulse_sync();
    send_byte(8'h3C, 1'b1);
    send_byte(8'h80, 1'b1);
    send_byte(8'h01, 1'b1);
    step(10);
    settle();
    chk("R7 drained valid", int'(pvalid), 0);
    chk("R4 drained fill", int'(fill), 0);
    chk("R1 queue consumed", expq.size(), 0);

    // R2: partial bits before a framing edge are discarded.
    step(1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    pulse_sync();
    send_byte(8'h5A, 1'b1);
    send_bit(1'b0); send_bit(1'b1);
    pulse_sync();
    send_byte(8'hC3, 1'b1);
    step(10);
    settle();
    chk("R2 realigned bytes consumed", expq.size(), 0);

    // R4/R5: fill with the consumer stalled.
    step(1);
    pready = 1'b0;
    for (int i = 0; i < REQ - 1; i++) send_byte(DW'(i * 7 + 3), 1'b1);
    settle();
    chk("R4 fill 63", int'(fill), REQ - 1);
    chk("R5 req_n at 63", int'(req_n), 0);
    chk("R7 valid while stalled", int'(pvalid), 1);
    step(1);
    send_byte(8'h77, 1'b1);
    settle();
    chk("R4 fill 64", int'(fill), REQ);
    chk("R5 req_n at 64", int'(req_n), 1);
    step(1);
    for (int i = REQ; i < DEPTH; i++) send_byte(DW'(i * 13 + 1), 1'b1);
    settle();
    chk("R4 fill full", int'(fill), DEPTH);
    chk("R6 ovf before drop", int'(ovf), 0);

    // R6: byte arriving while full is dropped.
    step(1);
    send_byte(8'hEE, 1'b0);
    settle();
    chk("R6 fill unchanged", int'(fill), DEPTH);
    chk("R6 ovf set", int'(ovf), 1);

    // R7: drain with an uneven ready pattern; scoreboard checks order.
    step(1);
    for (int i = 0; i < 700; i++) begin
      pready = (i % 5) != 2;
      step(1);
    end
    pready = 1'b1;
    step(20);
    settle();
    chk("R4 fill after drain", int'(fill), 0);
    chk("R7 valid after drain", int'(pvalid), 0);
    chk("R6 queue matched, drop absent", expq.size(), 0);
    chk("R6 ovf sticky", int'(ovf), 1);
    chk("R5 req_n after drain", int'(req_n), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule